// File: doc/BRIEF.md
# Tag-Only Set-Associative Cache Directory

This block records which memory blocks a set-associative cache would hold. It stores no data. It keeps only a tag and a valid flag for every way of every set. Each accepted request carries a byte address. The block splits the address into a block offset, a set index and a tag, and compares the tag against every way of the indexed set. It then reports whether the access hit and which way was involved.

On a miss, the block writes the tag into a way of that set. If the set has an empty way, the lowest empty way is used. Otherwise a victim is chosen by the replacement policy fixed at elaboration: least recently used, first-in first-out, or pseudo-random. Two running totals are kept, one counting all accesses and one counting misses. The block is meant as a hit/miss profiler placed beside an address stream.

The geometry comes from three power-of-two parameters: block size, number of ways and total capacity. The number of sets is the capacity divided by (block size × ways). A configuration that does not divide evenly stops elaboration.

Top module: `tag_directory`

## Requirements
- R1: With default parameters (64-byte blocks, 8 ways, 16384 bytes, so 32 sets), address bits [5:0] are the offset, bits [10:6] select the set and bits [31:11] form the tag. Two addresses that differ only in offset bits refer to the same entry, and the same tag in a different set is a separate entry.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. In the following cycle resp_valid is high and resp_hit is high exactly when a valid way of that set holds the request tag; on a hit resp_way gives that way.
- R3: On a miss in a set that still has an invalid way, the tag goes into the lowest-numbered invalid way, whatever the policy, and resp_way reports that way.
- R4: Least-recently-used policy: with every way valid, a miss replaces the way whose last hit or fill is oldest, with ties going to the lowest way number.
- R5: First-in first-out policy: with every way valid, a miss replaces the way that was filled earliest; hits do not change this order.
- R6: Pseudo-random policy: with every way valid, a miss replaces the way given by the low log2(ways) bits of a 16-bit register. The register starts at 16'hACE1 after reset and steps on every miss (fills into invalid ways included) to {r[14:0], r[15]^r[13]^r[12]^r[10]}.
- R7: access_count rises by one for every accepted request and miss_count rises by one for every miss; both new values are visible in the cycle after acceptance.
- R8: A cycle with req_valid low produces no response and changes neither counter nor any stored entry.
- R9: Requests on consecutive cycles to the same set see the entry written by the request before them.
- R10: A synchronous active-high reset invalidates every way, restores the replacement state, clears both counters and resp_valid, and holds req_ready low while asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (high outside reset) |
| req_addr | input | ADDR_W | Byte address of the request |
| resp_valid | output | 1 | Response present, one cycle after acceptance |
| resp_hit | output | 1 | Request hit in the directory |
| resp_way | output | log2(WAYS) | Way that hit or was filled |
| access_count | output | CNT_W | Accepted requests since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
Victim selection is the hardest thing to reach from the ports. It only happens once every way of a set is valid, and the way chosen depends on the history of hits and fills in that set. The stimulus first fills one set in order. It then touches an early way, so that the least-recently-used and first-in first-out choices differ, and then forces misses into the full set. The same stream drives one instance of each policy. For the random policy, a long run of distinct tags into a single set makes the register's low bits pick many different victims.

// File: rtl/tagdir_pkg.sv
`timescale 1ns/1ps
package tagdir_pkg;

    typedef enum logic [1:0] {
        REPL_LRU  = 2'd0,
        REPL_FIFO = 2'd1,
        REPL_RAND = 2'd2
    } repl_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/tagdir_probe.sv
`timescale 1ns/1ps
module tagdir_probe #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 21,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
    input  logic [TAG_W-1:0]            req_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        has_free,
    output logic [WAY_W-1:0]            free_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_valid[w] && (set_tags[w] == req_tag);
    end

    assign hit      = |match;
    assign has_free = ~&set_valid;

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])      hit_way  = WAY_W'(w);
            if (!set_valid[w]) free_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tagdir_victim.sv
`timescale 1ns/1ps
module tagdir_victim
    import tagdir_pkg::*;
#(
    parameter repl_e POLICY  = REPL_LRU,
    parameter int    SETS    = 32,
    parameter int    WAYS    = 8,
    parameter int    STAMP_W = 16,
    localparam int   WAY_W   = $clog2(WAYS),
    localparam int   IDX_W   = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_set,
    input  logic             upd_hit,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             has_free,
    input  logic [WAY_W-1:0] free_way,
    output logic [WAY_W-1:0] fill_way
);
    logic [WAY_W-1:0] repl_way;

    assign fill_way = has_free ? free_way : repl_way;

    if (POLICY == REPL_LRU) begin : g_lru
        logic [STAMP_W-1:0] gen_q   [SETS];
        logic [STAMP_W-1:0] stamp_q [SETS][WAYS];
        logic [STAMP_W-1:0] best;
        logic [WAY_W-1:0]   touch_way;

        assign touch_way = upd_hit ? hit_way : fill_way;

        always_comb begin
            repl_way = '0;
            best     = stamp_q[upd_set][0];
            for (int w = 1; w < WAYS; w++) begin
                if (stamp_q[upd_set][w] < best) begin
                    best     = stamp_q[upd_set][w];
                    repl_way = WAY_W'(w);
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) begin
                    gen_q[s] <= '0;
                    for (int w = 0; w < WAYS; w++) stamp_q[s][w] <= '0;
                end
            end else if (upd_en) begin
                stamp_q[upd_set][touch_way] <= gen_q[upd_set];
                gen_q[upd_set]              <= gen_q[upd_set] + 1'b1;
            end
        end
    end else if (POLICY == REPL_FIFO) begin : g_fifo
        logic [WAY_W-1:0] q_q    [SETS][WAYS];
        logic [WAY_W-1:0] head_q [SETS];
        logic [WAY_W:0]   cnt_q  [SETS];
        logic [WAY_W-1:0] tail;
        logic             unused_fifo;

        assign unused_fifo = ^hit_way;
        assign repl_way    = q_q[upd_set][head_q[upd_set]];
        assign tail        = head_q[upd_set] + cnt_q[upd_set][WAY_W-1:0];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) begin
                    head_q[s] <= '0;
                    cnt_q[s]  <= '0;
                    for (int w = 0; w < WAYS; w++) q_q[s][w] <= '0;
                end
            end else if (upd_en && !upd_hit) begin
                q_q[upd_set][tail] <= fill_way;
                if (cnt_q[upd_set] == (WAY_W + 1)'(WAYS))
                    head_q[upd_set] <= head_q[upd_set] + 1'b1;
                else
                    cnt_q[upd_set]  <= cnt_q[upd_set] + 1'b1;
            end
        end
    end else begin : g_rand
        logic [15:0] lfsr_q;
        logic        unused_rand;

        assign unused_rand = ^{upd_set, hit_way};
        assign repl_way    = lfsr_q[WAY_W-1:0];

        always_ff @(posedge clk) begin
            if (rst)                     lfsr_q <= LFSR_SEED;
            else if (upd_en && !upd_hit) lfsr_q <= lfsr_step(lfsr_q);
        end
    end
endmodule

// File: rtl/tag_directory.sv
`timescale 1ns/1ps
module tag_directory
    import tagdir_pkg::*;
#(
    parameter int    ADDR_W      = 32,
    parameter int    BLK_BYTES   = 64,
    parameter int    WAYS        = 8,
    parameter int    TOTAL_BYTES = 16384,
    parameter repl_e POLICY      = REPL_LRU,
    parameter int    STAMP_W     = 16,
    parameter int    CNT_W       = 32,
    localparam int   SETS        = TOTAL_BYTES / (BLK_BYTES * WAYS),
    localparam int   OFF_W       = $clog2(BLK_BYTES),
    localparam int   IDX_W       = $clog2(SETS),
    localparam int   TAG_W       = ADDR_W - IDX_W - OFF_W,
    localparam int   WAY_W       = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WAY_W-1:0]  resp_way,
    output logic [CNT_W-1:0]  access_count,
    output logic [CNT_W-1:0]  miss_count
);
    if (!is_pow2(BLK_BYTES) || !is_pow2(WAYS) || !is_pow2(TOTAL_BYTES) ||
        (TOTAL_BYTES % (BLK_BYTES * WAYS)) != 0 || SETS < 2 || WAYS < 2) begin : g_bad_geometry
        $error("tag_directory: geometry parameters do not divide into power-of-two sets");
    end

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } addr_fields_t;

    typedef struct packed {
        logic             hit;
        logic [WAY_W-1:0] way;
    } resp_t;

    addr_fields_t                    fld;
    logic [WAYS-1:0]                 valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]      tag_q   [SETS];
    logic                            fire, hit, has_free;
    logic [WAY_W-1:0]                hit_way, free_way, fill_way;
    logic                            unused_off;
    resp_t                           resp_q;
    logic                            resp_valid_q;
    logic [CNT_W-1:0]                acc_q, miss_q;

    assign fld        = addr_fields_t'(req_addr);
    assign unused_off = ^fld.off;
    assign req_ready  = ~rst;
    assign fire       = req_valid && req_ready;

    tagdir_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_probe (
        .set_valid (valid_q[fld.idx]),
        .set_tags  (tag_q[fld.idx]),
        .req_tag   (fld.tag),
        .hit       (hit),
        .hit_way   (hit_way),
        .has_free  (has_free),
        .free_way  (free_way)
    );

    tagdir_victim #(.POLICY(POLICY), .SETS(SETS), .WAYS(WAYS), .STAMP_W(STAMP_W)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (fire),
        .upd_set  (fld.idx),
        .upd_hit  (hit),
        .hit_way  (hit_way),
        .has_free (has_free),
        .free_way (free_way),
        .fill_way (fill_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fire && !hit) begin
            valid_q[fld.idx][fill_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fire && !hit) tag_q[fld.idx][fill_way] <= fld.tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid_q <= 1'b0;
            resp_q       <= '0;
            acc_q        <= '0;
            miss_q       <= '0;
        end else begin
            resp_valid_q <= fire;
            if (fire) begin
                resp_q.hit <= hit;
                resp_q.way <= hit ? hit_way : fill_way;
                acc_q      <= acc_q + 1'b1;
                if (!hit) miss_q <= miss_q + 1'b1;
            end
        end
    end

    assign resp_valid   = resp_valid_q;
    assign resp_hit     = resp_q.hit;
    assign resp_way     = resp_q.way;
    assign access_count = acc_q;
    assign miss_count   = miss_q;
endmodule

// File: rtl/tagdir_checker.sv
`timescale 1ns/1ps
module tagdir_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic [CNT_W-1:0] access_count,
    input logic [CNT_W-1:0] miss_count
);
    logic fire;
    assign fire = req_valid && req_ready;

    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        fire |=> resp_valid);

    a_r8_no_resp_when_idle: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !resp_valid);

    a_r7_access_increments: assert property (@(posedge clk) disable iff (rst)
        fire |=> access_count == CNT_W'($past(access_count) + 1'b1));

    a_r8_counters_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(access_count) && $stable(miss_count));

    a_r7_miss_increments: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> miss_count == CNT_W'($past(miss_count) + 1'b1));

    a_r7_hit_keeps_misses: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> $stable(miss_count));

    a_r7_misses_bounded: assert property (@(posedge clk) disable iff (rst)
        miss_count <= access_count);

    a_r10_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!resp_valid && access_count == '0 && miss_count == '0));
endmodule

bind tag_directory tagdir_checker #(.CNT_W(CNT_W)) u_tagdir_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .access_count (access_count),
    .miss_count   (miss_count)
);

// File: tb/tag_directory_test.sv
`timescale 1ns/1ps
module tag_directory_test;
    import tagdir_pkg::*;

    localparam int ADDR_W = 32;
    localparam int SETS   = 32;
    localparam int WAYS   = 8;
    localparam int OFF_W  = 6;
    localparam int IDX_W  = 5;
    localparam int WAY_W  = 3;
    localparam int CNT_W  = 32;
    localparam int NP     = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;

    logic             rdy [NP];
    logic             rv  [NP];
    logic             rh  [NP];
    logic [WAY_W-1:0] rw  [NP];
    logic [CNT_W-1:0] ac  [NP];
    logic [CNT_W-1:0] mc  [NP];

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tag_directory #(.POLICY(REPL_LRU)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[0]), .req_addr(req_addr),
        .resp_valid(rv[0]), .resp_hit(rh[0]), .resp_way(rw[0]),
        .access_count(ac[0]), .miss_count(mc[0]));
    tag_directory #(.POLICY(REPL_FIFO)) uut_fifo (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[1]), .req_addr(req_addr),
        .resp_valid(rv[1]), .resp_hit(rh[1]), .resp_way(rw[1]),
        .access_count(ac[1]), .miss_count(mc[1]));
    tag_directory #(.POLICY(REPL_RAND)) uut_rand (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[2]), .req_addr(req_addr),
        .resp_valid(rv[2]), .resp_hit(rh[2]), .resp_way(rw[2]),
        .access_count(ac[2]), .miss_count(mc[2]));

    // reference state: per policy, per set, per way
    logic              m_valid [NP][SETS][WAYS];
    logic [ADDR_W-1:0] m_tag   [NP][SETS][WAYS];
    int unsigned       m_time  [NP][SETS][WAYS];
    int unsigned       m_tick;
    int unsigned       m_acc;
    int unsigned       m_miss  [NP];
    logic [15:0]       m_lfsr;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_miss[p] = 0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    m_valid[p][s][w] = 1'b0;
                    m_tag[p][s][w]   = '0;
                    m_time[p][s][w]  = 0;
                end
        end
        m_tick = 1;
        m_acc  = 0;
        m_lfsr = 16'hACE1;
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
        return ADDR_W'((tag << (OFF_W + IDX_W)) | (set << OFF_W) | off);
    endfunction

    // one accepted request; leaves req_valid high so calls chain back-to-back
    task automatic access(input logic [ADDR_W-1:0] a, input string hit_rq);
        int s;
        logic [ADDR_W-1:0] tg;
        bit    e_hit [NP];
        int    e_way [NP];
        string w_rq  [NP];
        s  = int'((a >> OFF_W) & (SETS - 1));
        tg = a & ~ADDR_W'((1 << (OFF_W + IDX_W)) - 1);
        for (int p = 0; p < NP; p++) begin
            e_hit[p] = 0;
            e_way[p] = 0;
            for (int w = 0; w < WAYS; w++)
                if (!e_hit[p] && m_valid[p][s][w] && m_tag[p][s][w] == tg) begin
                    e_hit[p] = 1; e_way[p] = w;
                end
            if (e_hit[p]) begin
                w_rq[p] = (hit_rq == "") ? "R2" : hit_rq;
                if (p == 0) m_time[p][s][e_way[p]] = m_tick;
            end else begin
                int fw;
                fw = -1;
                for (int w = WAYS - 1; w >= 0; w--)
                    if (!m_valid[p][s][w]) fw = w;
                if (fw >= 0) begin
                    w_rq[p] = "R3";
                end else if (p == 2) begin
                    w_rq[p] = "R6";
                    fw = int'(m_lfsr[WAY_W-1:0]);
                end else begin
                    int unsigned oldest;
                    w_rq[p] = (p == 0) ? "R4" : "R5";
                    fw = 0; oldest = m_time[p][s][0];
                    for (int w = 1; w < WAYS; w++)
                        if (m_time[p][s][w] < oldest) begin
                            oldest = m_time[p][s][w]; fw = w;
                        end
                end
                if (p == 2) m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
                m_valid[p][s][fw] = 1'b1;
                m_tag[p][s][fw]   = tg;
                m_time[p][s][fw]  = m_tick;
                m_miss[p]++;
                e_way[p] = fw;
            end
        end
        m_tick++;
        m_acc++;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk(rv[p] == 1'b1, "R2", $sformatf("p%0d resp_valid", p), rv[p], 1);
            chk(rh[p] == e_hit[p], "R2", $sformatf("p%0d hit addr=%h", p, a), rh[p], e_hit[p]);
            chk(int'(rw[p]) == e_way[p], w_rq[p], $sformatf("p%0d way addr=%h", p, a), rw[p], e_way[p]);
            chk(ac[p] == m_acc, "R7", $sformatf("p%0d access_count", p), ac[p], m_acc);
            chk(mc[p] == m_miss[p], "R7", $sformatf("p%0d miss_count", p), mc[p], m_miss[p]);
        end
    endtask

    task automatic idle(input int cycles);
        req_valid = 1'b0;
        req_addr  = '1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                chk(rv[p] == 1'b0, "R8", $sformatf("p%0d no response", p), rv[p], 0);
                chk(ac[p] == m_acc, "R8", $sformatf("p%0d access hold", p), ac[p], m_acc);
                chk(mc[p] == m_miss[p], "R8", $sformatf("p%0d miss hold", p), mc[p], m_miss[p]);
            end
        end
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            chk(rdy[p] == 1'b0, "R10", $sformatf("p%0d ready low in reset", p), rdy[p], 0);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk(rv[p] == 1'b0, "R10", $sformatf("p%0d resp_valid after reset", p), rv[p], 0);
            chk(ac[p] == 0, "R10", $sformatf("p%0d access_count after reset", p), ac[p], 0);
            chk(mc[p] == 0, "R10", $sformatf("p%0d miss_count after reset", p), mc[p], 0);
            chk(rdy[p] == 1'b1, "R10", $sformatf("p%0d ready after reset", p), rdy[p], 1);
        end
    endtask

    task automatic t_cold_fill();   // R3: ways fill in order 0..7
        for (int t = 1; t <= WAYS; t++) access(mk(t, 3, 0), "");
        idle(1);
    endtask

    task automatic t_hits_offsets(); // R1: offset ignored, set separates entries
        for (int t = 1; t <= WAYS; t++) access(mk(t, 3, (t * 7) % 64), "R1");
        access(mk(1, 3, 63), "R1");
        access(mk(2, 4, 0), "");       // same tag, other set: miss
        idle(2);
    endtask

    task automatic t_evict_full_set(); // R4/R5/R6 diverge after way 0 was re-touched
        access(mk(1, 3, 0), "");
        access(mk(9, 3, 0), "");
        access(mk(10, 3, 4), "");
        access(mk(3, 3, 0), "");
        access(mk(11, 3, 0), "");
        access(mk(1, 3, 0), "");
        access(mk(12, 3, 0), "");
        idle(1);
    endtask

    task automatic t_random_stream(); // R6: many victims in one full set
        for (int t = 20; t < 48; t++) access(mk(t, 5, 0), "");
        for (int t = 40; t < 48; t++) access(mk(t, 5, 8), "");
        idle(1);
    endtask

    task automatic t_back_to_back(); // R9: fill then immediate re-use of same set
        access(mk(100, 7, 0), "");
        access(mk(100, 7, 1), "R9");
        access(mk(101, 7, 0), "");
        access(mk(100, 7, 2), "R9");
        access(mk(101, 7, 3), "R9");
        idle(1);
    endtask

    task automatic t_reset_clears(); // R10: previously held tags miss after reset
        do_reset();
        access(mk(1, 3, 0), "");
        access(mk(100, 7, 0), "");
        idle(1);
    endtask

    initial begin
        model_reset();
        do_reset();
        t_cold_fill();
        t_hits_offsets();
        t_evict_full_set();
        t_random_stream();
        t_back_to_back();
        t_reset_clears();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule